// File: doc/BRIEF.md
# Stereo Serial Sample Transmitter (Externally Clocked)

This block sends a pair of 18-bit stereo samples, one left and one right, out of one serial data pin. The host supplies three timing signals: a bit clock, a word clock that marks the channel halves, and a frame-enable strobe. The block is clocked by a faster system clock. It synchronises all three external signals into that domain and reacts to their edges. The left word goes out while the word clock is high and the right word goes out while it is low. A new data bit is presented after each falling edge of the bit clock.

A 3-bit mode code selects the transfer style:
- MSB first.
- LSB first.
- MSB first, with each bit advance gated by the frame-enable strobe.

The number of bits in a word is set by how many bit clocks the host provides in each half. Fewer than 18 truncates the word, and any clocks past the 18th produce zeros. Both samples and the mode are captured when the word clock rises. A one-cycle request strobe then tells the sample source it may present the next pair. Holding the power-down input high clears the transmitter. After release, nothing is sent until the next rising edge of the word clock, which is how the host aligns the block.

Top module: `stereo_slave_tx`

## Requirements
- R1: While `pdn_i` is high, `sdata_o` is 0 one cycle later and `req_o` stays 0. After reset `sdata_o` and `req_o` are 0.
- R2: After `pdn_i` falls, `sdata_o` stays 0 for every bit clock until the first rising edge of the word clock. That edge starts a frame.
- R3: `sdata_o` changes only in response to a falling bit-clock edge (or to power-down), never while the bit clock is high.
- R4: In mode `3'b000` the channel word is sent MSB first: bit 17 after the first falling bit-clock edge, down to bit 0 after the 18th. The left word is sent while the word clock is high and the right word while it is low.
- R5: In mode `3'b001` the channel word is sent LSB first: bit 0 after the first falling edge, up to bit 17 after the 18th.
- R6: In mode `3'b010` bits go out MSB first, but a falling bit-clock edge with the frame-enable input low outputs 0 and does not advance the bit position.
- R7: Falling bit-clock edges beyond the 18th sent bit of a channel output 0.
- R8: A channel half with fewer than 18 bit clocks sends only that many leading bits. The next half starts again from its first bit.
- R9: Both sample words are captured at the word-clock rising edge. Changes to `left_i`/`right_i` later in the frame do not alter the bits sent.
- R10: `req_o` pulses high for exactly one cycle once per word-clock rising edge (outside power-down).
- R11: Mode codes other than `000`, `001` and `010` behave as `000`. The mode is captured at the word-clock rising edge, so mid-frame changes take effect on the next frame.
- R12: In modes `000` and `001` the frame-enable input has no effect on `sdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn_i | input | 1 | Power-down; high clears and disarms the transmitter |
| mode_i | input | 3 | Transfer mode code |
| bclk_i | input | 1 | External bit clock |
| wclk_i | input | 1 | External word clock; high = left half, low = right half |
| fen_i | input | 1 | External frame-enable strobe |
| left_i | input | SAMPLE_W | Left-channel sample |
| right_i | input | SAMPLE_W | Right-channel sample |
| sdata_o | output | 1 | Serial data bit |
| req_o | output | 1 | One-cycle request for the next sample pair |

## Verification
Frames run with seeded random sample pairs, channel lengths from 16 to 128 bit clocks, and random frame-enable patterns. These stimuli separate MSB-first from LSB-first ordering, zero padding from truncated words, and gated from ungated bit advance. Directed frames cover two things. One is the power-down release before the first word-clock rise, which shows whether the block waits for alignment. The other is sample and mode changes injected mid-frame, which reveal a missing holding register or a mode that is not captured per frame. Illegal mode codes, and frame-enable toggling in the ungated modes, must give the same bits as mode `000`.

// File: rtl/sdt_pkg.sv
package sdt_pkg;

   typedef enum logic [1:0] {
      ORD_MSB   = 2'd0,
      ORD_LSB   = 2'd1,
      ORD_GATED = 2'd2
   } xfer_mode_e;

   // Unlisted codes fall back to plain MSB-first transfer.
   function automatic xfer_mode_e decode_mode(input logic [2:0] code);
      case (code)
         3'b001:  return ORD_LSB;
         3'b010:  return ORD_GATED;
         default: return ORD_MSB;
      endcase
   endfunction

endpackage

// File: rtl/sdt_sync.sv
module sdt_sync #(
   parameter int N      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d_i,
   output logic [N-1:0] lvl_o,
   output logic [N-1:0] chg_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sdt_sync: STAGES must be at least 2");
   end
   if (N < 1) begin : g_bad_n
      $error("sdt_sync: N must be at least 1");
   end

   logic [STAGES-1:0][N-1:0] stg_q;
   logic [N-1:0]             last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q  <= '0;
         last_q <= '0;
      end else begin
         stg_q  <= {stg_q[STAGES-2:0], d_i};
         last_q <= stg_q[STAGES-1];
      end
   end

   assign lvl_o = stg_q[STAGES-1];
   assign chg_o = stg_q[STAGES-1] ^ last_q;

endmodule

// File: rtl/sdt_hold.sv
module sdt_hold #(
   parameter int W = 18
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic         sel_left_i,
   input  logic [W-1:0] left_i,
   input  logic [W-1:0] right_i,
   output logic [W-1:0] word_o
);

   logic [W-1:0] left_q, right_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q  <= '0;
         right_q <= '0;
      end else if (load_i) begin
         left_q  <= left_i;
         right_q <= right_i;
      end
   end

   // On the capture cycle the fresh left sample is forwarded directly.
   assign word_o = load_i     ? left_i :
                   sel_left_i ? left_q : right_q;

endmodule

// File: rtl/sdt_shifter.sv
module sdt_shifter #(
   parameter int W = 18
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         restart_i,
   input  logic         fall_i,
   input  logic         armed_i,
   input  logic         lsb_first_i,
   input  logic         gated_i,
   input  logic         fen_i,
   input  logic [W-1:0] word_i,
   output logic         bit_o
);

   localparam int             CW   = $clog2(W + 1);
   localparam logic [CW-1:0]  LAST = CW'(W);

   logic [CW-1:0] idx_q, base, pos;
   logic [W-1:0]  shifted;
   logic          in_word, hold_gate;

   assign base      = restart_i ? '0 : idx_q;
   assign in_word   = (base < LAST);
   assign pos       = lsb_first_i ? base : (LAST - 1'b1 - base);
   assign shifted   = word_i >> pos;
   assign hold_gate = gated_i && !fen_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         bit_o <= 1'b0;
      end else if (clr_i) begin
         idx_q <= '0;
         bit_o <= 1'b0;
      end else if (fall_i) begin
         if (!armed_i || hold_gate || !in_word) begin
            bit_o <= 1'b0;
            idx_q <= base;
         end else begin
            bit_o <= shifted[0];
            idx_q <= base + 1'b1;
         end
      end else if (restart_i) begin
         idx_q <= '0;
      end
   end

   assert_idx_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= LAST);

   assert_pad_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_i && !restart_i && idx_q == LAST) |=> !bit_o);

   assert_gate_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_i && gated_i && !fen_i && !restart_i && !clr_i) |=> ($stable(idx_q) && !bit_o));

endmodule

// File: rtl/stereo_slave_tx.sv
module stereo_slave_tx
   import sdt_pkg::*;
#(
   parameter int SAMPLE_W    = 18,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pdn_i,
   input  logic [2:0]          mode_i,
   input  logic                bclk_i,
   input  logic                wclk_i,
   input  logic                fen_i,
   input  logic [SAMPLE_W-1:0] left_i,
   input  logic [SAMPLE_W-1:0] right_i,
   output logic                sdata_o,
   output logic                req_o
);

   if (SAMPLE_W < 2) begin : g_bad_width
      $error("stereo_slave_tx: SAMPLE_W must be at least 2");
   end

   localparam int NSIG = 3;

   logic [NSIG-1:0] lvl, chg;
   logic            b_fall, w_rise, w_fall, restart;
   logic            armed_q, armed_eff, req_q;
   logic            unused_fen_chg;
   xfer_mode_e      mode_q, mode_eff;
   logic [SAMPLE_W-1:0] cur_word;

   sdt_sync #(.N(NSIG), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({fen_i, wclk_i, bclk_i}),
      .lvl_o (lvl),
      .chg_o (chg)
   );

   assign b_fall         = chg[0] & ~lvl[0];
   assign w_rise         = chg[1] &  lvl[1];
   assign w_fall         = chg[1] & ~lvl[1];
   assign restart        = w_rise | w_fall;
   assign unused_fen_chg = chg[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         mode_q  <= ORD_MSB;
         req_q   <= 1'b0;
      end else begin
         req_q <= w_rise & ~pdn_i;
         if (pdn_i)       armed_q <= 1'b0;
         else if (w_rise) armed_q <= 1'b1;
         if (w_rise)      mode_q  <= decode_mode(mode_i);
      end
   end

   assign armed_eff = ~pdn_i & (armed_q | w_rise);
   assign mode_eff  = w_rise ? decode_mode(mode_i) : mode_q;

   sdt_hold #(.W(SAMPLE_W)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (w_rise),
      .sel_left_i (lvl[1]),
      .left_i     (left_i),
      .right_i    (right_i),
      .word_o     (cur_word)
   );

   sdt_shifter #(.W(SAMPLE_W)) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (pdn_i),
      .restart_i   (restart),
      .fall_i      (b_fall),
      .armed_i     (armed_eff),
      .lsb_first_i (mode_eff == ORD_LSB),
      .gated_i     (mode_eff == ORD_GATED),
      .fen_i       (lvl[2]),
      .word_i      (cur_word),
      .bit_o       (sdata_o)
   );

   assign req_o = req_q;

   assert_pdn_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      pdn_i |=> (!sdata_o && !req_o));

   assert_wait_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && !w_rise) |=> !sdata_o);

   assert_fall_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!b_fall && !pdn_i) |=> $stable(sdata_o));

   assert_req_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |=> !req_o);

endmodule

// File: tb/stereo_slave_tx_tb.sv
`timescale 1ns/1ps
module stereo_slave_tx_tb;

   localparam int W = 18;
   localparam int H = 6;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         pdn_i = 1'b1;
   logic [2:0]   mode_i = 3'b000;
   logic         bclk_i = 1'b1;
   logic         wclk_i = 1'b0;
   logic         fen_i = 1'b1;
   logic [W-1:0] left_i = '0;
   logic [W-1:0] right_i = '0;
   logic         sdata_o, req_o;

   int checks = 0;
   int errors = 0;
   int req_cnt = 0;
   int pulse_err = 0;
   int r3_err = 0;
   bit done = 1'b0;
   logic prev_req = 1'b0;
   logic prev_sd = 1'b0;

   always #5 clk = ~clk;

   stereo_slave_tx #(.SAMPLE_W(W), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .pdn_i(pdn_i), .mode_i(mode_i),
      .bclk_i(bclk_i), .wclk_i(wclk_i), .fen_i(fen_i),
      .left_i(left_i), .right_i(right_i),
      .sdata_o(sdata_o), .req_o(req_o)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (req_o) req_cnt++;
         if (req_o && prev_req) pulse_err++;
         if (sdata_o !== prev_sd && bclk_i && !pdn_i) r3_err++;
      end
      prev_req = req_o;
      prev_sd  = sdata_o;
   end

   function automatic logic [2:0] eff_mode(input logic [2:0] code);
      if (code == 3'b001 || code == 3'b010) return code;
      return 3'b000;
   endfunction

   task automatic chk(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s sdata actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic chk_int(input int act, input int exp, input string tag);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // One channel half: wclk takes level wl at the first bit slot.
   task automatic chan(input logic wl, input int n, input logic [W-1:0] w,
                       input logic [2:0] code, input bit zero_exp,
                       input bit rnd_fen, input bit mid_change, input string tag);
      logic [2:0] m;
      int   idx;
      logic exp;
      string t;
      m   = eff_mode(code);
      idx = 0;
      for (int b = 0; b < n; b++) begin
         if (b == 0) wclk_i = wl;
         fen_i = rnd_fen ? (($urandom % 4) != 0) : 1'b1;
         if (mid_change && b == 3) begin
            left_i  = W'($urandom);
            right_i = W'($urandom);
            mode_i  = 3'($urandom);
         end
         repeat (H) @(negedge clk);
         bclk_i = 1'b0;
         repeat (H) @(negedge clk);
         t = tag;
         if (zero_exp) exp = 1'b0;
         else if (m == 3'b010 && !fen_i) exp = 1'b0;
         else if (idx < W) begin
            exp = (m == 3'b001) ? w[idx] : w[W-1-idx];
            idx++;
         end else begin
            exp = 1'b0;
            t = {tag, "/R7"};
         end
         chk(sdata_o, exp, t);
         bclk_i = 1'b1;
      end
   endtask

   task automatic frame(input logic [2:0] code, input logic [W-1:0] l,
                        input logic [W-1:0] r, input int nl, input int nr,
                        input bit rnd_fen, input bit mid_change, input string tag);
      int r0;
      mode_i  = code;
      left_i  = l;
      right_i = r;
      r0 = req_cnt;
      chan(1'b1, nl, l, code, 1'b0, rnd_fen, mid_change, tag);
      chan(1'b0, nr, r, code, 1'b0, rnd_fen, 1'b0, tag);
      chk_int(req_cnt - r0, 1, "R10 request pulses per frame");
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R4 watchdog actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [2:0] codes [8];
      void'($urandom(32'h5EED_0C1A));
      codes = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b101, 3'b110, 3'b111};

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(sdata_o, 1'b0, "R1 reset sdata");
      chk(req_o, 1'b0, "R1 reset req");

      // Power-down held through a full frame.
      left_i = 18'h3FFFF; right_i = 18'h3FFFF;
      chan(1'b1, 32, left_i, 3'b000, 1'b1, 1'b0, 1'b0, "R1");
      chan(1'b0, 32, right_i, 3'b000, 1'b1, 1'b0, 1'b0, "R1");
      chk_int(req_cnt, 0, "R1 no request in power-down");

      // Release while wclk is low: silence until the rising edge.
      @(negedge clk); pdn_i = 1'b0;
      chan(1'b0, 20, 18'h3FFFF, 3'b000, 1'b1, 1'b0, 1'b0, "R2");
      frame(3'b000, 18'h2A5C3, 18'h15A3C, 32, 32, 1'b0, 1'b0, "R2/R4");

      // Directed modes and lengths.
      frame(3'b000, 18'h20001, 18'h1FFFE, 18, 18, 1'b0, 1'b0, "R4");
      frame(3'b001, 18'h0F0F1, 18'h30C35, 64, 64, 1'b0, 1'b0, "R5");
      frame(3'b010, 18'h2BEEF, 18'h1CAFE, 40, 40, 1'b1, 1'b0, "R6");
      frame(3'b000, 18'h3ABCD, 18'h01234, 16, 16, 1'b0, 1'b0, "R8");
      frame(3'b001, 18'h3ABCD, 18'h01234, 10, 17, 1'b0, 1'b0, "R8");
      frame(3'b000, 18'h12345, 18'h2468A, 128, 128, 1'b0, 1'b0, "R7");
      frame(3'b000, 18'h1C3A5, 18'h0E1F7, 32, 32, 1'b0, 1'b1, "R9/R11");
      frame(3'b101, 18'h2D2D2, 18'h13579, 32, 32, 1'b0, 1'b0, "R11");
      frame(3'b111, 18'h00001, 18'h20000, 24, 24, 1'b0, 1'b0, "R11");
      frame(3'b000, 18'h3C3C3, 18'h0A0A0, 32, 32, 1'b1, 1'b0, "R12");
      frame(3'b001, 18'h3C3C3, 18'h0A0A0, 64, 64, 1'b1, 1'b0, "R12");

      // Power-down in the middle of a left half, then realignment.
      mode_i = 3'b000; left_i = 18'h3F00F; right_i = 18'h00FF0;
      chan(1'b1, 5, 18'h3F00F, 3'b000, 1'b0, 1'b0, 1'b0, "R4");
      @(negedge clk); pdn_i = 1'b1;
      chan(1'b1, 10, 18'h3F00F, 3'b000, 1'b1, 1'b0, 1'b0, "R1");
      @(negedge clk); pdn_i = 1'b0;
      chan(1'b1, 10, 18'h3F00F, 3'b000, 1'b1, 1'b0, 1'b0, "R2");
      chan(1'b0, 32, 18'h00FF0, 3'b000, 1'b1, 1'b0, 1'b0, "R2");
      frame(3'b010, 18'h15555, 18'h2AAAA, 48, 48, 1'b1, 1'b0, "R2/R6");

      // Seeded random frames.
      for (int f = 0; f < 10; f++) begin
         logic [2:0] c;
         int nl, nr;
         string tg;
         c  = codes[$urandom % 8];
         nl = (eff_mode(c) == 3'b001) ? 64 : 16 + int'($urandom % 113);
         nr = (eff_mode(c) == 3'b001) ? 64 : 16 + int'($urandom % 113);
         if (c > 3'b010)            tg = "R11";
         else if (c == 3'b001)      tg = "R5/R12";
         else if (c == 3'b010)      tg = "R6";
         else                       tg = "R4/R12";
         frame(c, W'($urandom), W'($urandom), nl, nr, 1'b1, ($urandom % 2) == 1, tg);
      end

      chk_int(pulse_err, 0, "R10 request pulse wider than one cycle");
      chk_int(r3_err, 0, "R3 data change while bit clock high");

      done = 1'b1;
      summary();
      $finish;
   end

endmodule